// File: doc/BRIEF.md
# Segment Descriptor Translation Checker

This block turns a segment selector and an offset into a linear address. The selector does not hold a base. It holds a table index, a table-select bit and a requested privilege level. The block keeps two small on-chip descriptor tables: a shared global one and a per-process local one. Software loads both through a single write port. Each descriptor holds a base, a byte limit, a descriptor privilege level, attribute bits, a present flag and an accessed flag.

For each request the block reads the chosen descriptor and derives the effective privilege. The effective privilege is the less privileged of the caller's current level and the selector's requested level. The block then checks presence, privilege and limit in that priority order. It returns either base plus offset or one fault code. A successful access marks the descriptor as accessed. Requests can be issued every cycle, and each result appears two clock edges later on registered outputs.

Top module: `seg_xlate`

## Requirements
- R1: Selector layout: bits [1:0] are the requested privilege level, bit 2 picks the table (0 global, 1 local), and bits [SEL_W-1:3] are the entry index. The two tables are independent: the same index in each table refers to a different descriptor.
- R2: A request sampled on a clock edge gives `rsp_valid` high after the second edge that follows. On success `rsp_fault` is 0 and `rsp_lin` = base + offset modulo 2^32. When `rsp_valid` is low, `rsp_lin`, `rsp_fault`, `rsp_attr` and `rsp_acc_prev` are all zero.
- R3: After reset, every entry of both tables reads as not present and not accessed, and all outputs are zero.
- R4: A descriptor whose present flag is clear gives fault code 1 (absent). This fault takes precedence over every other fault.
- R5: The effective level is max(`req_cpl`, selector requested level). If it is numerically greater than the descriptor level, fault code 2 (privilege) is reported. This fault takes precedence over the limit fault.
- R6: An offset greater than the zero-extended limit gives fault code 3 (limit). An offset equal to the limit is allowed.
- R7: On any fault, `rsp_lin` and `rsp_attr` are zero and the descriptor's accessed flag is left unchanged.
- R8: A successful access sets the descriptor's accessed flag on the edge that registers the result. `rsp_acc_prev` reports the flag as it was before that access, so a back-to-back second access to the same entry reports 1.
- R9: If a table write hits the same entry on the same edge as an accessed-flag set, the written `wr_accessed` value is kept.
- R10: A written descriptor is seen by any request sampled on a later edge, and `rsp_attr` returns its attribute bits on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_local | input | 1 | Write target: 0 global, 1 local table |
| wr_index | input | IDX_W | Entry to write |
| wr_base | input | BASE_W | Segment base |
| wr_limit | input | LIMIT_W | Highest valid byte offset |
| wr_dpl | input | 2 | Descriptor privilege level |
| wr_present | input | 1 | Present flag |
| wr_attr | input | ATTR_W | Attribute bits |
| wr_accessed | input | 1 | Initial accessed flag |
| req_valid | input | 1 | Translation request |
| req_sel | input | SEL_W | Selector |
| req_off | input | OFF_W | Offset within segment |
| req_cpl | input | 2 | Current privilege level |
| rsp_valid | output | 1 | Result valid |
| rsp_lin | output | BASE_W | Linear address, zero on fault |
| rsp_fault | output | 2 | 0 none, 1 absent, 2 privilege, 3 limit |
| rsp_attr | output | ATTR_W | Descriptor attributes on success |
| rsp_acc_prev | output | 1 | Accessed flag before this access |

## Verification
Two operations can touch one stored accessed flag on the same edge: the flag set from a finishing access and a software write to that same entry. The bench sends a request and drives a write of the same entry, with the accessed flag cleared, on the edge where that request completes. The following access must then report a cleared flag, and the access after that must report it set. A separate case sends two back-to-back requests to a fresh entry, where the second result must already show the flag set by the first.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PRIV   = 2'd2,
    FLT_LIMIT  = 2'd3
  } fault_e;

  localparam int SEL_RPL_LSB = 0;
  localparam int SEL_TBL_BIT = 2;
  localparam int SEL_IDX_LSB = 3;
endpackage

// File: rtl/seg_tbl.sv
module seg_tbl #(
  parameter int DEPTH   = 16,
  parameter int BASE_W  = 32,
  parameter int LIMIT_W = 20,
  parameter int ATTR_W  = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int MEM_W  = BASE_W + LIMIT_W + 2 + ATTR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [BASE_W-1:0]  wr_base,
  input  logic [LIMIT_W-1:0] wr_limit,
  input  logic [1:0]         wr_dpl,
  input  logic [ATTR_W-1:0]  wr_attr,
  input  logic               wr_present,
  input  logic               wr_acc,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [BASE_W-1:0]  rd_base_q,
  output logic [LIMIT_W-1:0] rd_limit_q,
  output logic [1:0]         rd_dpl_q,
  output logic [ATTR_W-1:0]  rd_attr_q,
  output logic               rd_present_q,
  input  logic [IDX_W-1:0]   acc_idx,
  output logic               acc_bit,
  input  logic               set_en,
  input  logic [IDX_W-1:0]   set_idx
);
  logic [MEM_W-1:0] mem [DEPTH];
  logic [MEM_W-1:0] mem_q;
  logic [DEPTH-1:0] pres;
  logic [DEPTH-1:0] acc;

  // Descriptor body: plain synchronous RAM, no reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_base, wr_limit, wr_dpl, wr_attr};
    mem_q <= mem[rd_idx];
  end

  assign {rd_base_q, rd_limit_q, rd_dpl_q, rd_attr_q} = mem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pres         <= '0;
      rd_present_q <= 1'b0;
    end else begin
      if (wr_en) pres[wr_idx] <= wr_present;
      rd_present_q <= pres[rd_idx];
    end
  end

  // Accessed flags: the write port is ordered last so it wins a collision
  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else begin
      if (set_en) acc[set_idx] <= 1'b1;
      if (wr_en)  acc[wr_idx]  <= wr_acc;
    end
  end

  assign acc_bit = acc[acc_idx];

  AST_CLEAR_ON_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pres == '0) && (acc == '0)); // R3
  AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
    set_en && !(wr_en && wr_idx == set_idx) |=> acc[$past(set_idx)]); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> acc[$past(wr_idx)] == $past(wr_acc)); // R9
endmodule

// File: rtl/seg_chk.sv
module seg_chk
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W   = 32,
  parameter int LIMIT_W = 20
) (
  input  logic               present,
  input  logic [1:0]         dpl,
  input  logic [LIMIT_W-1:0] limit,
  input  logic [OFF_W-1:0]   off,
  input  logic [1:0]         cpl,
  input  logic [1:0]         rpl,
  output fault_e             fault
);
  logic [1:0] eff;
  logic       priv_bad;
  logic       over_limit;

  always_comb begin
    eff        = (cpl > rpl) ? cpl : rpl;
    priv_bad   = eff > dpl;
    over_limit = off > OFF_W'(limit);
    if (!present)        fault = FLT_ABSENT;
    else if (priv_bad)   fault = FLT_PRIV;
    else if (over_limit) fault = FLT_LIMIT;
    else                 fault = FLT_NONE;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int TBL_DEPTH = 16,
  parameter int BASE_W    = 32,
  parameter int OFF_W     = 32,
  parameter int LIMIT_W   = 20,
  parameter int ATTR_W    = 4,
  localparam int IDX_W    = $clog2(TBL_DEPTH),
  localparam int SEL_W    = IDX_W + SEL_IDX_LSB
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_local,
  input  logic [IDX_W-1:0]   wr_index,
  input  logic [BASE_W-1:0]  wr_base,
  input  logic [LIMIT_W-1:0] wr_limit,
  input  logic [1:0]         wr_dpl,
  input  logic               wr_present,
  input  logic [ATTR_W-1:0]  wr_attr,
  input  logic               wr_accessed,
  input  logic               req_valid,
  input  logic [SEL_W-1:0]   req_sel,
  input  logic [OFF_W-1:0]   req_off,
  input  logic [1:0]         req_cpl,
  output logic               rsp_valid,
  output logic [BASE_W-1:0]  rsp_lin,
  output logic [1:0]         rsp_fault,
  output logic [ATTR_W-1:0]  rsp_attr,
  output logic               rsp_acc_prev
);
  localparam int NTBL = 2;

  logic [IDX_W-1:0] req_idx;
  logic             req_tbl;
  assign req_idx = req_sel[SEL_W-1:SEL_IDX_LSB];
  assign req_tbl = req_sel[SEL_TBL_BIT];

  // Stage registers alongside the table read
  logic             p_valid;
  logic             p_tbl;
  logic [IDX_W-1:0] p_idx;
  logic [1:0]       p_rpl;
  logic [1:0]       p_cpl;
  logic [OFF_W-1:0] p_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_valid <= 1'b0;
      p_tbl   <= 1'b0;
      p_idx   <= '0;
      p_rpl   <= '0;
      p_cpl   <= '0;
      p_off   <= '0;
    end else begin
      p_valid <= req_valid;
      p_tbl   <= req_tbl;
      p_idx   <= req_idx;
      p_rpl   <= req_sel[SEL_RPL_LSB +: 2];
      p_cpl   <= req_cpl;
      p_off   <= req_off;
    end
  end

  logic [BASE_W-1:0]  t_base    [NTBL];
  logic [LIMIT_W-1:0] t_limit   [NTBL];
  logic [1:0]         t_dpl     [NTBL];
  logic [ATTR_W-1:0]  t_attr    [NTBL];
  logic               t_present [NTBL];
  logic               t_acc     [NTBL];
  logic               set_ok;

  for (genvar t = 0; t < NTBL; t++) begin : g_tbl
    seg_tbl #(
      .DEPTH   (TBL_DEPTH),
      .BASE_W  (BASE_W),
      .LIMIT_W (LIMIT_W),
      .ATTR_W  (ATTR_W)
    ) u_tbl (
      .clk          (clk),
      .rst          (rst),
      .wr_en        (wr_en && (wr_local == 1'(t))),
      .wr_idx       (wr_index),
      .wr_base      (wr_base),
      .wr_limit     (wr_limit),
      .wr_dpl       (wr_dpl),
      .wr_attr      (wr_attr),
      .wr_present   (wr_present),
      .wr_acc       (wr_accessed),
      .rd_idx       (req_idx),
      .rd_base_q    (t_base[t]),
      .rd_limit_q   (t_limit[t]),
      .rd_dpl_q     (t_dpl[t]),
      .rd_attr_q    (t_attr[t]),
      .rd_present_q (t_present[t]),
      .acc_idx      (p_idx),
      .acc_bit      (t_acc[t]),
      .set_en       (set_ok && (p_tbl == 1'(t))),
      .set_idx      (p_idx)
    );
  end

  logic [BASE_W-1:0]  cur_base;
  logic [LIMIT_W-1:0] cur_limit;
  logic [1:0]         cur_dpl;
  logic [ATTR_W-1:0]  cur_attr;
  logic               cur_present;
  logic               cur_acc;
  fault_e             cur_fault;

  assign cur_base    = t_base[p_tbl];
  assign cur_limit   = t_limit[p_tbl];
  assign cur_dpl     = t_dpl[p_tbl];
  assign cur_attr    = t_attr[p_tbl];
  assign cur_present = t_present[p_tbl];
  assign cur_acc     = t_acc[p_tbl];

  seg_chk #(.OFF_W(OFF_W), .LIMIT_W(LIMIT_W)) u_chk (
    .present (cur_present),
    .dpl     (cur_dpl),
    .limit   (cur_limit),
    .off     (p_off),
    .cpl     (p_cpl),
    .rpl     (p_rpl),
    .fault   (cur_fault)
  );

  assign set_ok = p_valid && (cur_fault == FLT_NONE);

  always_ff @(posedge clk) begin
    if (rst || !p_valid) begin
      rsp_valid    <= 1'b0;
      rsp_lin      <= '0;
      rsp_fault    <= FLT_NONE;
      rsp_attr     <= '0;
      rsp_acc_prev <= 1'b0;
    end else begin
      rsp_valid    <= 1'b1;
      rsp_fault    <= cur_fault;
      rsp_acc_prev <= cur_acc;
      rsp_lin      <= set_ok ? cur_base + BASE_W'(p_off) : '0;
      rsp_attr     <= set_ok ? cur_attr : '0;
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid, 2)); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_lin == '0) && (rsp_fault == 2'd0) && !rsp_acc_prev); // R2
  AST_ABSENT_FIRST: assert property (@(posedge clk) disable iff (rst)
    p_valid && !cur_present |=> rsp_fault == FLT_ABSENT); // R4
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && (rsp_fault != 2'd0) |-> (rsp_lin == '0) && (rsp_attr == '0)); // R7
  AST_LIMIT_ONLY_PRESENT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && (rsp_fault == FLT_LIMIT) |-> $past(cur_present)); // R6
endmodule

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;
  localparam int IDX_W = 4;
  localparam int SEL_W = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_local = 1'b0, wr_present = 1'b0, wr_accessed = 1'b0;
  logic [IDX_W-1:0] wr_index = '0;
  logic [31:0] wr_base = '0;
  logic [19:0] wr_limit = '0;
  logic [1:0]  wr_dpl = '0;
  logic [3:0]  wr_attr = '0;
  logic        req_valid = 1'b0;
  logic [SEL_W-1:0] req_sel = '0;
  logic [31:0] req_off = '0;
  logic [1:0]  req_cpl = '0;
  logic        rsp_valid, rsp_acc_prev;
  logic [31:0] rsp_lin;
  logic [1:0]  rsp_fault;
  logic [3:0]  rsp_attr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seg_xlate dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_local(wr_local), .wr_index(wr_index),
    .wr_base(wr_base), .wr_limit(wr_limit), .wr_dpl(wr_dpl), .wr_present(wr_present),
    .wr_attr(wr_attr), .wr_accessed(wr_accessed), .req_valid(req_valid),
    .req_sel(req_sel), .req_off(req_off), .req_cpl(req_cpl), .rsp_valid(rsp_valid),
    .rsp_lin(rsp_lin), .rsp_fault(rsp_fault), .rsp_attr(rsp_attr),
    .rsp_acc_prev(rsp_acc_prev)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic loc, logic [3:0] idx, logic [31:0] base, logic [19:0] lim,
                    logic [1:0] dpl, logic pres, logic [3:0] attr, logic acc);
    @(negedge clk);
    wr_en = 1; wr_local = loc; wr_index = idx; wr_base = base; wr_limit = lim;
    wr_dpl = dpl; wr_present = pres; wr_attr = attr; wr_accessed = acc;
    @(negedge clk);
    wr_en = 0;
  endtask

  // Issue one request, wait two edges, sample at the following negedge
  task automatic xlate(logic [6:0] sel, logic [1:0] cpl, logic [31:0] off);
    @(negedge clk);
    req_valid = 1; req_sel = sel; req_cpl = cpl; req_off = off;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
  endtask

  // {sel, cpl, off, fault, lin, acc_prev}; sel = idx<<3 | tbl<<2 | rpl
  localparam int NV = 12;
  localparam logic [75:0] VEC [NV] = '{
    {7'h00, 2'd0, 32'h0000_0010, 2'd0, 32'h1000_0010, 1'b0}, // R2 global ok
    {7'h03, 2'd3, 32'h0000_0FFF, 2'd0, 32'h1000_0FFF, 1'b1}, // R6 off==limit, R8
    {7'h00, 2'd0, 32'h0000_1000, 2'd3, 32'h0000_0000, 1'b1}, // R6 limit
    {7'h08, 2'd0, 32'h0000_0080, 2'd0, 32'h2000_0080, 1'b0}, // R1 index 1 global
    {7'h09, 2'd0, 32'h0000_0080, 2'd2, 32'h0000_0000, 1'b1}, // R5 rpl weaker
    {7'h08, 2'd1, 32'h0000_0200, 2'd2, 32'h0000_0000, 1'b1}, // R5 priv beats limit
    {7'h10, 2'd3, 32'h0000_0999, 2'd1, 32'h0000_0000, 1'b0}, // R4 absent beats all
    {7'h0C, 2'd2, 32'h0001_2345, 2'd0, 32'h3001_2345, 1'b0}, // R1 index 1 local
    {7'h0F, 2'd0, 32'h0000_0000, 2'd2, 32'h0000_0000, 1'b1}, // R5 rpl3 vs dpl2
    {7'h07, 2'd3, 32'h0000_1800, 2'd0, 32'h0000_0800, 1'b0}, // R2 wraps modulo
    {7'h2C, 2'd0, 32'h0000_0000, 2'd1, 32'h0000_0000, 1'b0}, // R4 unwritten local
    {7'h04, 2'd0, 32'h0000_2000, 2'd3, 32'h0000_0000, 1'b1}  // R7 fault keeps acc
  };

  initial begin
    repeat (3) @(negedge clk);
    // R3 reset state
    chk("R3 rsp_valid", 32'(rsp_valid), 0);
    chk("R3 rsp_lin", rsp_lin, 0);
    chk("R3 rsp_fault", 32'(rsp_fault), 0);
    rst = 0;
    xlate(7'h00, 2'd0, 32'h0);
    chk("R3 absent after reset", 32'(rsp_fault), 1);
    @(negedge clk);
    chk("R2 idle zero", {rsp_valid, rsp_lin[30:0]}, 0);

    wr(0, 0, 32'h1000_0000, 20'h00FFF, 2'd3, 1, 4'hA, 0);
    wr(0, 1, 32'h2000_0000, 20'h000FF, 2'd0, 1, 4'h1, 0);
    wr(0, 2, 32'h5000_0000, 20'h00000, 2'd0, 0, 4'h2, 0);
    wr(1, 1, 32'h3000_0000, 20'hFFFFF, 2'd2, 1, 4'h3, 0);
    wr(1, 0, 32'hFFFF_F000, 20'h01FFF, 2'd3, 1, 4'h4, 0);

    for (int i = 0; i < NV; i++) begin
      xlate(VEC[i][75:69], VEC[i][68:67], VEC[i][66:35]);
      chk($sformatf("R2 vec%0d valid", i), 32'(rsp_valid), 1);
      chk($sformatf("R4/R5/R6 vec%0d fault", i), 32'(rsp_fault), 32'(VEC[i][34:33]));
      chk($sformatf("R2/R7 vec%0d lin", i), rsp_lin, VEC[i][32:1]);
      chk($sformatf("R8 vec%0d acc", i), 32'(rsp_acc_prev), 32'(VEC[i][0]));
    end

    // R10 attributes and preset accessed flag
    wr(0, 4, 32'h6000_0000, 20'h0000F, 2'd3, 1, 4'h5, 1);
    xlate(7'h20, 2'd0, 32'h4);
    chk("R10 attr", 32'(rsp_attr), 5);
    chk("R10 lin", rsp_lin, 32'h6000_0004);
    chk("R10 acc preset", 32'(rsp_acc_prev), 1);

    // R9 collision: write same entry on the edge the access completes
    wr(0, 3, 32'h4000_0000, 20'h000FF, 2'd3, 1, 4'h6, 0);
    @(negedge clk);
    req_valid = 1; req_sel = 7'h18; req_cpl = 0; req_off = 0;
    @(negedge clk);
    req_valid = 0;
    wr_en = 1; wr_local = 0; wr_index = 3; wr_base = 32'h4000_0000; wr_limit = 20'h000FF;
    wr_dpl = 3; wr_present = 1; wr_attr = 4'h6; wr_accessed = 0;
    @(negedge clk);
    wr_en = 0;
    chk("R9 collided access ok", 32'(rsp_fault), 0);
    xlate(7'h18, 2'd0, 32'h1);
    chk("R9 write value kept", 32'(rsp_acc_prev), 0);
    xlate(7'h18, 2'd0, 32'h2);
    chk("R8 set after clean access", 32'(rsp_acc_prev), 1);

    // R8 back-to-back requests to one fresh entry
    wr(1, 2, 32'h7000_0000, 20'h000FF, 2'd0, 1, 4'h7, 0);
    @(negedge clk);
    req_valid = 1; req_sel = 7'h14; req_cpl = 0; req_off = 32'h10;
    @(negedge clk);
    req_off = 32'h20;
    @(negedge clk);
    req_valid = 0;
    chk("R8 first lin", rsp_lin, 32'h7000_0010);
    chk("R8 first acc", 32'(rsp_acc_prev), 0);
    @(negedge clk);
    chk("R2 second lin", rsp_lin, 32'h7000_0020);
    chk("R8 second acc", 32'(rsp_acc_prev), 1);

    // R3 reset again clears tables
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    xlate(7'h00, 2'd3, 32'h0);
    chk("R3 absent after second reset", 32'(rsp_fault), 1);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule